// File: doc/BRIEF.md
# Threshold Sensor Cell with Neighbor Pass-Through

This block is the digital part of a reconfigurable sensor tile in an array where tiles talk only to their four nearest neighbors. It holds a 3-bit code that sets one of eight detection levels on an external analog receiver. It registers the receiver's one-bit decision in a single flip-flop, and that flip-flop drives the cell output. When the cell is not used as a sensor, the flip-flop instead follows a chosen neighbor (north, east, west or south) every cycle. The analog receiver is slow, so a new sample is accepted only when a programmable number of logic-clock cycles has passed since the last accepted one.

The cell is set up by a 6-bit word shifted through a two-phase master/slave chain. The shift data comes either from an electrical serial pin or from the optical receiver bit. Outside the configuration chain, the same flip-flop is a stage of a test scan chain. A synchronous user reset clears that flip-flop and leaves the configuration alone.

Top module: `threshold_sensor_cell`

## Requirements
- R1: While `cfg_en` is high, a `cfg_clk_a` cycle loads each master stage: the top stage takes the serial input and every other stage takes the slave above it. A later `cfg_clk_b` cycle copies all masters into the slaves. Bits therefore enter at bit 5 and move toward bit 0, so the first bit shifted ends at bit 0 after six A/B pairs. `cfg_out` is slave bit 0.
- R2: While `cfg_en` is low, phase pulses leave the configuration word unchanged.
- R3: `cfg_src`=0 takes shift data from `cfg_in`, and `cfg_src`=1 takes it from `rx_bit`.
- R4: `thresh` equals configuration bits [2:0].
- R5: When configuration bit 3 (sensor enable) is 0 and test mode is off, the flip-flop loads a neighbor every cycle. The neighbor is chosen by bits [5:4]: 00 north, 01 east, 10 west, 11 south.
- R6: With the sensor enabled and test mode off, the flip-flop loads `rx_bit` only on an accepted strobe and otherwise holds its value.
- R7: A strobe is accepted only if at least `sample_gap` cycles have passed since the previously accepted one. The first strobe after user reset is accepted. Strobes seen while the sensor is disabled or in test mode are not counted.
- R8: In test mode the flip-flop loads `scan_in`. Both `scan_out` and `cell_out` always show the flip-flop.
- R9: `user_rst` clears the flip-flop on the next edge, takes priority over test mode and leaves the configuration word and `thresh` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| user_rst | input | 1 | Synchronous user reset of the data flip-flop |
| test_mode | input | 1 | Flip-flop loads scan_in |
| scan_in | input | 1 | Test scan data in |
| scan_out | output | 1 | Test scan data out |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_clk_a | input | 1 | Configuration phase A (master load) |
| cfg_clk_b | input | 1 | Configuration phase B (slave load) |
| cfg_src | input | 1 | 0: electrical serial in, 1: optical bit |
| cfg_in | input | 1 | Electrical configuration serial in |
| cfg_out | output | 1 | Configuration serial out |
| rx_bit | input | 1 | Receiver decision (also optical config data) |
| rx_strobe | input | 1 | Receiver sample strobe |
| sample_gap | input | GAP_W | Minimum cycles between accepted samples |
| nb_north | input | 1 | North neighbor signal |
| nb_east | input | 1 | East neighbor signal |
| nb_west | input | 1 | West neighbor signal |
| nb_south | input | 1 | South neighbor signal |
| thresh | output | 3 | Detector threshold code to receiver |
| cell_out | output | 1 | Cell output to neighbors |

## Verification
Pass-through is tried with one neighbor high at a time, then with random neighbor values under random select codes. This separates a wrong select decode from a stuck path. The sensor path gets sparse random strobes with random gaps, plus a directed pair of strobes at one cycle short of the gap and exactly at the gap. This separates an off-by-one pacing compare from a hold fault. Configuration is loaded electrically with the optical bit set to the inverse data, and then the other way round, which shows whether the source select is swapped. Phase pulses with the enable low check that the word is held.

// File: rtl/sensor_cell_pkg.sv
package sensor_cell_pkg;
    localparam int CFG_BITS = 6;
    localparam int THR_W    = 3;
    localparam int NBR_CNT  = 4;

    typedef enum logic [1:0] {
        NB_NORTH = 2'b00,
        NB_EAST  = 2'b01,
        NB_WEST  = 2'b10,
        NB_SOUTH = 2'b11
    } nbr_sel_e;

    typedef struct packed {
        nbr_sel_e         sel;
        logic             sensor_en;
        logic [THR_W-1:0] thr;
    } cell_cfg_t;
endpackage

// File: rtl/sc_cfg_chain.sv
module sc_cfg_chain #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         user_rst,
    input  logic         shift_en,
    input  logic         ph_a,
    input  logic         ph_b,
    input  logic         sin,
    output logic [N-1:0] word,
    output logic         sout
);
    typedef struct packed {
        logic [N-1:0] mst;
        logic [N-1:0] slv;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en && ph_a) begin
            for (int i = 0; i < N; i++) begin
                st_d.mst[i] = (i == N-1) ? sin : st_q.slv[i+1];
            end
        end
        if (shift_en && ph_b) begin
            st_d.slv = st_q.mst;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word = st_q.slv;
    assign sout = st_q.slv[0];

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (user_rst)
        !shift_en |=> $stable(word));

    // R1
    cfg_shift_chk: assert property (@(posedge clk) disable iff (user_rst)
        (shift_en && ph_a && !ph_b) ##1 (shift_en && ph_b && !ph_a)
        |=> (word == {$past(sin, 2), $past(word[N-1:1], 2)}));
endmodule

// File: rtl/sc_sample_pacer.sv
module sc_sample_pacer #(
    parameter int GAP_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             strobe,
    input  logic [GAP_W-1:0] gap,
    output logic             accept
);
    localparam logic [GAP_W-1:0] CNT_MAX = '1;
    localparam logic [GAP_W-1:0] CNT_ONE = GAP_W'(1);

    typedef struct packed {
        logic [GAP_W-1:0] cnt;
    } pace_t;

    pace_t st_d, st_q;

    assign accept = en && strobe && (st_q.cnt >= gap);

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
        if (accept) begin
            st_d.cnt = CNT_ONE;
        end
        if (rst) begin
            st_d.cnt = CNT_MAX;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R7
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && gap > CNT_ONE) |=> !accept);
endmodule

// File: rtl/sc_data_reg.sv
module sc_data_reg
    import sensor_cell_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               test,
    input  logic               scan_in,
    input  logic               sensor_en,
    input  logic               accept,
    input  logic               rx_bit,
    input  logic [NBR_CNT-1:0] nbr,
    input  nbr_sel_e           sel,
    output logic               q
);
    typedef struct packed {
        logic q;
    } dreg_t;

    dreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.q = 1'b0;
        end else if (test) begin
            st_d.q = scan_in;
        end else if (sensor_en) begin
            if (accept) begin
                st_d.q = rx_bit;
            end
        end else begin
            st_d.q = nbr[sel];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.q;

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !q);

    // R8
    scan_load_chk: assert property (@(posedge clk) disable iff (rst)
        test |=> (q == $past(scan_in)));

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (!test && !sensor_en) |=> (q == $past(nbr[sel])));

    // R6
    sensor_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!test && sensor_en && !accept) |=> $stable(q));
endmodule

// File: rtl/threshold_sensor_cell.sv
module threshold_sensor_cell
    import sensor_cell_pkg::*;
#(
    parameter int GAP_W = 7
) (
    input  logic             clk,
    input  logic             user_rst,
    input  logic             test_mode,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic             cfg_en,
    input  logic             cfg_clk_a,
    input  logic             cfg_clk_b,
    input  logic             cfg_src,
    input  logic             cfg_in,
    output logic             cfg_out,
    input  logic             rx_bit,
    input  logic             rx_strobe,
    input  logic [GAP_W-1:0] sample_gap,
    input  logic             nb_north,
    input  logic             nb_east,
    input  logic             nb_west,
    input  logic             nb_south,
    output logic [THR_W-1:0] thresh,
    output logic             cell_out
);
    logic [CFG_BITS-1:0] cfg_word;
    cell_cfg_t           cfg;
    logic                shift_bit;
    logic [NBR_CNT-1:0]  nbr_v;
    logic                accept;
    logic                q;

    assign shift_bit = cfg_src ? rx_bit : cfg_in;

    sc_cfg_chain #(.N(CFG_BITS)) i_chain (
        .clk      (clk),
        .user_rst (user_rst),
        .shift_en (cfg_en),
        .ph_a     (cfg_clk_a),
        .ph_b     (cfg_clk_b),
        .sin      (shift_bit),
        .word     (cfg_word),
        .sout     (cfg_out)
    );

    assign cfg   = cell_cfg_t'(cfg_word);
    assign nbr_v = {nb_south, nb_west, nb_east, nb_north};

    sc_sample_pacer #(.GAP_W(GAP_W)) i_pacer (
        .clk    (clk),
        .rst    (user_rst),
        .en     (cfg.sensor_en && !test_mode),
        .strobe (rx_strobe),
        .gap    (sample_gap),
        .accept (accept)
    );

    sc_data_reg i_dreg (
        .clk       (clk),
        .rst       (user_rst),
        .test      (test_mode),
        .scan_in   (scan_in),
        .sensor_en (cfg.sensor_en),
        .accept    (accept),
        .rx_bit    (rx_bit),
        .nbr       (nbr_v),
        .sel       (cfg.sel),
        .q         (q)
    );

    assign thresh   = cfg.thr;
    assign cell_out = q;
    assign scan_out = q;

    // R9
    cfg_kept_chk: assert property (@(posedge clk) disable iff (cfg_en)
        user_rst |=> $stable(thresh));
endmodule

// File: tb/test_threshold_sensor_cell.sv
module test_threshold_sensor_cell;
    logic       clk = 1'b0;
    logic       user_rst = 1'b1;
    logic       test_mode = 1'b0, scan_in = 1'b0;
    logic       cfg_en = 1'b0, cfg_clk_a = 1'b0, cfg_clk_b = 1'b0;
    logic       cfg_src = 1'b0, cfg_in = 1'b0;
    logic       rx_bit = 1'b0, rx_strobe = 1'b0;
    logic [6:0] sample_gap = 7'd50;
    logic       nb_north = 1'b0, nb_east = 1'b0, nb_west = 1'b0, nb_south = 1'b0;
    logic       scan_out, cfg_out, cell_out;
    logic [2:0] thresh;

    int checks = 0;
    int errors = 0;

    threshold_sensor_cell i_threshold_sensor_cell (
        .clk(clk), .user_rst(user_rst), .test_mode(test_mode), .scan_in(scan_in),
        .scan_out(scan_out), .cfg_en(cfg_en), .cfg_clk_a(cfg_clk_a),
        .cfg_clk_b(cfg_clk_b), .cfg_src(cfg_src), .cfg_in(cfg_in),
        .cfg_out(cfg_out), .rx_bit(rx_bit), .rx_strobe(rx_strobe),
        .sample_gap(sample_gap), .nb_north(nb_north), .nb_east(nb_east),
        .nb_west(nb_west), .nb_south(nb_south), .thresh(thresh), .cell_out(cell_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements
    logic [5:0] m_mst, m_slv;
    logic       m_q;
    int         m_cnt;
    string      m_tag = "R9";
    bit         chk_on = 1'b0;
    bit         m_acc;

    function automatic logic pick_nbr(input logic [1:0] s);
        case (s)
            2'b00:   return nb_north;
            2'b01:   return nb_east;
            2'b10:   return nb_west;
            default: return nb_south;
        endcase
    endfunction

    always @(posedge clk) begin
        if (cfg_en && cfg_clk_a) m_mst <= {(cfg_src ? rx_bit : cfg_in), m_slv[5:1]};
        if (cfg_en && cfg_clk_b) m_slv <= m_mst;
        if (user_rst) begin
            m_q   <= 1'b0;
            m_cnt <= 127;
            m_tag <= "R9";
        end else begin
            m_acc = m_slv[3] && !test_mode && rx_strobe && (m_cnt >= int'(sample_gap));
            m_cnt <= m_acc ? 1 : ((m_cnt == 127) ? 127 : m_cnt + 1);
            if (test_mode) begin
                m_q <= scan_in; m_tag <= "R8";
            end else if (m_slv[3]) begin
                if (m_acc) begin m_q <= rx_bit; m_tag <= "R7"; end
                else m_tag <= "R6";
            end else begin
                m_q <= pick_nbr(m_slv[5:4]); m_tag <= "R5";
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            chk(m_tag, cell_out, m_q);
            chk("R8 scan_out", scan_out, m_q);
            chk("R4", thresh, m_slv[2:0]);
            chk("R1 cfg_out", cfg_out, m_slv[0]);
        end
    end

    task automatic shift_word(input logic [5:0] w, input logic src);
        cfg_src = src;
        for (int i = 0; i < 6; i++) begin
            cfg_en = 1'b1; cfg_clk_a = 1'b1;
            if (src) begin rx_bit = w[i]; cfg_in = ~w[i]; end
            else begin cfg_in = w[i]; rx_bit = ~w[i]; end
            @(negedge clk);
            cfg_clk_a = 1'b0; cfg_clk_b = 1'b1;
            @(negedge clk);
            cfg_clk_b = 1'b0;
        end
        cfg_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        // sel=E(01), sensor off, threshold 5, electrical
        shift_word(6'b01_0_101, 1'b0);
        @(negedge clk);
        chk_on = 1'b1;
        chk("R9 reset state", cell_out, 0);
        chk("R1 electrical load", thresh, 5);
        user_rst = 1'b0;
        nb_east = 1'b1;
        @(negedge clk);
        chk("R5 east selected", cell_out, 1);
        nb_east = 1'b0; nb_north = 1'b1; nb_west = 1'b1; nb_south = 1'b1;
        @(negedge clk);
        chk("R5 others ignored", cell_out, 0);
        // phase pulses with enable low
        cfg_en = 1'b0; cfg_in = 1'b1; rx_bit = 1'b1;
        for (int k = 0; k < 6; k++) begin
            cfg_clk_a = 1'b1; @(negedge clk);
            cfg_clk_a = 1'b0; cfg_clk_b = 1'b1; @(negedge clk);
            cfg_clk_b = 1'b0;
        end
        chk("R2 word held", thresh, 5);
        // sel=S(11), sensor on, threshold 2, optical
        shift_word(6'b11_1_010, 1'b1);
        @(negedge clk);
        chk("R3 optical load", thresh, 2);
        chk("R3 cfg_out", cfg_out, 0);
        // pacing
        sample_gap = 7'd50;
        user_rst = 1'b1; @(negedge clk); user_rst = 1'b0;
        rx_strobe = 1'b1; rx_bit = 1'b1;
        @(negedge clk);
        chk("R7 first strobe after reset", cell_out, 1);
        rx_strobe = 1'b0;
        for (int k = 0; k < 48; k++) begin
            rx_bit = 1'($urandom);
            @(negedge clk);
        end
        chk("R6 hold without strobe", cell_out, 1);
        rx_strobe = 1'b1; rx_bit = 1'b0;
        @(negedge clk);
        chk("R7 strobe before gap rejected", cell_out, 1);
        @(negedge clk);
        chk("R7 strobe at gap accepted", cell_out, 0);
        rx_strobe = 1'b0;
        // test scan
        test_mode = 1'b1; scan_in = 1'b1;
        @(negedge clk);
        chk("R8 scan load 1", scan_out, 1);
        scan_in = 1'b0;
        @(negedge clk);
        chk("R8 scan load 0", scan_out, 0);
        scan_in = 1'b1; user_rst = 1'b1;
        @(negedge clk);
        chk("R9 reset beats test", cell_out, 0);
        chk("R9 config kept", thresh, 2);
        user_rst = 1'b0; test_mode = 1'b0;
        // random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 300 == 0) begin
                shift_word(6'($urandom), 1'($urandom));
            end else begin
                user_rst   = ($urandom % 150 == 0);
                test_mode  = ($urandom % 40 == 0);
                rx_strobe  = ($urandom % 6 == 0);
                rx_bit     = 1'($urandom);
                scan_in    = 1'($urandom);
                nb_north   = 1'($urandom);
                nb_east    = 1'($urandom);
                nb_west    = 1'($urandom);
                nb_south   = 1'($urandom);
                if ($urandom % 500 == 0) sample_gap = 7'(50 + $urandom % 51);
                @(negedge clk);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule